// File: doc/BRIEF.md
# Same-Row Two-Key Chord Decoder

This block watches the scan lines of a 4x4 common-contact keypad and reports up to two keys held down together, as long as both keys sit in the same row. The inputs are four row lines and four column lines. Every line is active low and reads high when no key is down. A pressed key pulls its own row line and its own column line low. If two keys in one row are held, one row line and two column lines are low.

The block has two result slots, each with a 4-bit key code and a valid flag. A lone key always lands in slot A and leaves slot B empty. A same-row pair is split by column: slot A takes the left key and slot B the right key. Some patterns cannot be read as one key or a same-row pair: no row low, several rows low, a row with no column, or three or more columns. For these, both slots are cleared. The result is registered, so it appears one clock after the lines are sampled. The lines must already be synchronized to the clock.

Top module: `chord_pair_decoder`

## Requirements
- R1: While the synchronous active-low reset is sampled low at a rising edge, both valid flags and both codes are 0 after that edge.
- R2: With exactly one row line i low and exactly one column line j low, slot A is valid with code 4*i + j, and slot B is not valid with code 0. Bit k of each line bus belongs to row or column k, and index 0 is the upper-left corner.
- R3: With exactly one row line i low and exactly two column lines j < k low, both slots are valid. Slot A carries 4*i + j and slot B carries 4*i + k.
- R4: With two or more row lines low, both flags are 0 and both codes read 0, whatever the columns show.
- R5: With no row line low, both flags are 0 and both codes read 0, even when column lines are low.
- R6: With exactly one row line low and no column line low, both flags are 0 and both codes read 0.
- R7: With exactly one row line low and three or more column lines low, both flags are 0 and both codes read 0.
- R8: The outputs change only at a rising clock edge. They show the decode of the lines sampled at the previous edge and do not follow input changes between edges.
- R9: Slot B is never valid unless slot A is valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| row_n | input | 4 | Row lines, active low, bit k = row k |
| col_n | input | 4 | Column lines, active low, bit k = column k |
| valid_a | output | 1 | Slot A holds a key |
| code_a | output | 4 | Slot A key code (single key, or left key of a pair) |
| valid_b | output | 1 | Slot B holds a key |
| code_b | output | 4 | Slot B key code (right key of a pair) |

## Verification
The bench tries every lone key and every same-row pair. It checks that a lone key never shows up in slot B. It checks that a pair keeps the left key in slot A, so a scan in the wrong direction would show up as swapped codes. The rejects get their own directed cases, followed by a long biased random run: a row with no column must not give code 4*i, three columns must not be cut down to a pair, and a column pattern with no row, or with two rows, must not decode as a key. Between edges the bench also confirms that the outputs still show the last decode, which catches any combinational path from input to output.

// File: rtl/chord_pkg.sv
package chord_pkg;

    // Classification of a sampled line pattern
    typedef enum logic [1:0] {
        PAT_REJECT = 2'd0,
        PAT_SINGLE = 2'd1,
        PAT_PAIR   = 2'd2
    } pat_e;

    // Saturating count of asserted column lines
    typedef enum logic [1:0] {
        CNT_ZERO = 2'd0,
        CNT_ONE  = 2'd1,
        CNT_TWO  = 2'd2,
        CNT_MANY = 2'd3
    } cnt_e;

endpackage

// File: rtl/chord_row_scan.sv
module chord_row_scan #(
    parameter int ROWS = 4,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic [ROWS-1:0] row_n,
    output logic            row_one,
    output logic [RW-1:0]   row_idx
);

    logic [ROWS-1:0] row_act;

    // Active-low lines flipped to active-high, one per row
    for (genvar g = 0; g < ROWS; g++) begin : g_row_inv
        assign row_act[g] = ~row_n[g];
    end

    logic seen_d;
    logic multi_d;
    logic [RW-1:0] idx_d;

    always_comb begin
        seen_d  = 1'b0;
        multi_d = 1'b0;
        idx_d   = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (row_act[r]) begin
                if (seen_d) begin
                    multi_d = 1'b1;
                end
                seen_d = 1'b1;
                idx_d  = RW'(r);
            end
        end
    end

    assign row_one = seen_d & ~multi_d;
    assign row_idx = row_one ? idx_d : '0;

endmodule

// File: rtl/chord_col_scan.sv
module chord_col_scan
    import chord_pkg::*;
#(
    parameter int COLS = 4,
    localparam int CLW = $clog2(COLS)
) (
    input  logic [COLS-1:0] col_n,
    output cnt_e            col_cnt,
    output logic [CLW-1:0]  col_lo,
    output logic [CLW-1:0]  col_hi
);

    logic [COLS-1:0] col_act;

    for (genvar g = 0; g < COLS; g++) begin : g_col_inv
        assign col_act[g] = ~col_n[g];
    end

    logic [1:0]     cnt_d;
    logic [CLW-1:0] lo_d;
    logic [CLW-1:0] hi_d;

    // Saturating population count
    always_comb begin
        cnt_d = 2'd0;
        for (int j = 0; j < COLS; j++) begin
            if (col_act[j] && (cnt_d != 2'd3)) begin
                cnt_d = cnt_d + 2'd1;
            end
        end
    end

    // Lowest asserted index: scan downward, last hit wins
    always_comb begin
        lo_d = '0;
        for (int j = COLS - 1; j >= 0; j--) begin
            if (col_act[j]) begin
                lo_d = CLW'(j);
            end
        end
    end

    // Highest asserted index: scan upward, last hit wins
    always_comb begin
        hi_d = '0;
        for (int j = 0; j < COLS; j++) begin
            if (col_act[j]) begin
                hi_d = CLW'(j);
            end
        end
    end

    assign col_cnt = cnt_e'(cnt_d);
    assign col_lo  = lo_d;
    assign col_hi  = hi_d;

endmodule

// File: rtl/chord_pair_pack.sv
module chord_pair_pack
    import chord_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int RW  = $clog2(ROWS),
    localparam int CLW = $clog2(COLS),
    localparam int CW  = $clog2(ROWS * COLS)
) (
    input  logic           row_one,
    input  logic [RW-1:0]  row_idx,
    input  cnt_e           col_cnt,
    input  logic [CLW-1:0] col_lo,
    input  logic [CLW-1:0] col_hi,
    output pat_e           pat,
    output logic [CW-1:0]  key_lo,
    output logic [CW-1:0]  key_hi
);

    localparam logic [CW-1:0] STRIDE = CW'(COLS);

    logic [CW-1:0] base;

    assign base = CW'(row_idx) * STRIDE;

    always_comb begin
        pat    = PAT_REJECT;
        key_lo = '0;
        key_hi = '0;
        if (row_one) begin
            unique case (col_cnt)
                CNT_ONE: begin
                    pat    = PAT_SINGLE;
                    key_lo = base + CW'(col_lo);
                end
                CNT_TWO: begin
                    pat    = PAT_PAIR;
                    key_lo = base + CW'(col_lo);
                    key_hi = base + CW'(col_hi);
                end
                default: begin
                    pat = PAT_REJECT;
                end
            endcase
        end
    end

endmodule

// File: rtl/chord_pair_decoder.sv
module chord_pair_decoder
    import chord_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int RW  = $clog2(ROWS),
    localparam int CLW = $clog2(COLS),
    localparam int CW  = $clog2(ROWS * COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] row_n,
    input  logic [COLS-1:0] col_n,
    output logic            valid_a,
    output logic [CW-1:0]   code_a,
    output logic            valid_b,
    output logic [CW-1:0]   code_b
);

    typedef struct packed {
        logic          va;
        logic [CW-1:0] ca;
        logic          vb;
        logic [CW-1:0] cb;
    } slot_t;

    logic           row_one;
    logic [RW-1:0]  row_idx;
    cnt_e           col_cnt;
    logic [CLW-1:0] col_lo;
    logic [CLW-1:0] col_hi;
    pat_e           pat;
    logic [CW-1:0]  key_lo;
    logic [CW-1:0]  key_hi;

    chord_row_scan #(.ROWS(ROWS)) u_rows (
        .row_n  (row_n),
        .row_one(row_one),
        .row_idx(row_idx)
    );

    chord_col_scan #(.COLS(COLS)) u_cols (
        .col_n  (col_n),
        .col_cnt(col_cnt),
        .col_lo (col_lo),
        .col_hi (col_hi)
    );

    chord_pair_pack #(.ROWS(ROWS), .COLS(COLS)) u_pack (
        .row_one(row_one),
        .row_idx(row_idx),
        .col_cnt(col_cnt),
        .col_lo (col_lo),
        .col_hi (col_hi),
        .pat    (pat),
        .key_lo (key_lo),
        .key_hi (key_hi)
    );

    slot_t slot_d;
    slot_t slot_q;

    always_comb begin
        slot_d = '0;
        unique case (pat)
            PAT_SINGLE: begin
                slot_d.va = 1'b1;
                slot_d.ca = key_lo;
            end
            PAT_PAIR: begin
                slot_d.va = 1'b1;
                slot_d.ca = key_lo;
                slot_d.vb = 1'b1;
                slot_d.cb = key_hi;
            end
            default: begin
                slot_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign valid_a = slot_q.va;
    assign code_a  = slot_q.ca;
    assign valid_b = slot_q.vb;
    assign code_b  = slot_q.cb;

endmodule

// File: rtl/chord_pair_decoder_chk.sv
module chord_pair_decoder_chk #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int CW  = $clog2(ROWS * COLS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ROWS-1:0] row_n,
    input logic [COLS-1:0] col_n,
    input logic            valid_a,
    input logic [CW-1:0]   code_a,
    input logic            valid_b,
    input logic [CW-1:0]   code_b
);

    assert_b_needs_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_b |-> valid_a);

    assert_empty_codes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_a |-> (code_a == '0 && code_b == '0));

    assert_pair_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_b |-> (code_a < code_b &&
                     (int'(code_a) / COLS) == (int'(code_b) / COLS)));

    assert_multi_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~row_n) > 1) |=> (!valid_a && !valid_b));

    assert_no_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (&row_n) |=> (!valid_a && !valid_b));

    assert_bare_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~row_n) == 1 && (&col_n)) |=> (!valid_a && !valid_b));

    assert_many_cols_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~col_n) > 2) |=> (!valid_a && !valid_b));

    assert_single_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~row_n) == 1 && $countones(~col_n) == 1)
            |=> (valid_a && !valid_b));

    assert_pair_slots_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~row_n) == 1 && $countones(~col_n) == 2)
            |=> (valid_a && valid_b));

endmodule

bind chord_pair_decoder chord_pair_decoder_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (.*);

// File: tb/chord_pair_decoder_test.sv
module chord_pair_decoder_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] row_n;
    logic [3:0] col_n;
    logic       valid_a;
    logic [3:0] code_a;
    logic       valid_b;
    logic [3:0] code_b;

    int total = 0;
    int bad   = 0;
    logic [9:0] prev_exp = '0;

    always #5 clk = ~clk;

    chord_pair_decoder uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .row_n  (row_n),
        .col_n  (col_n),
        .valid_a(valid_a),
        .code_a (code_a),
        .valid_b(valid_b),
        .code_b (code_b)
    );

    function automatic int ones4(input logic [3:0] v);
        int n = 0;
        for (int k = 0; k < 4; k++) if (v[k]) n++;
        return n;
    endfunction

    // Expected {valid_a, code_a, valid_b, code_b} from the requirements
    function automatic logic [9:0] model(input logic [3:0] r, input logic [3:0] c);
        int nr = ones4(~r);
        int nc = ones4(~c);
        int ri = 0;
        int lo = -1;
        int hi = -1;
        if (nr != 1 || nc < 1 || nc > 2) return '0;
        for (int k = 0; k < 4; k++) if (!r[k]) ri = k;
        for (int k = 0; k < 4; k++) if (!c[k]) begin
            if (lo < 0) lo = k;
            hi = k;
        end
        if (nc == 1) return {1'b1, 4'(4 * ri + lo), 1'b0, 4'd0};
        return {1'b1, 4'(4 * ri + lo), 1'b1, 4'(4 * ri + hi)};
    endfunction

    function automatic string tag(input logic [3:0] r, input logic [3:0] c);
        int nr = ones4(~r);
        int nc = ones4(~c);
        if (nr == 0) return "R5";
        if (nr > 1)  return "R4";
        if (nc == 0) return "R6";
        if (nc > 2)  return "R7";
        if (nc == 1) return "R2";
        return "R3";
    endfunction

    task automatic compare(input logic [9:0] exp, input string req);
        logic [9:0] act = {valid_a, code_a, valid_b, code_b};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s row_n=%b col_n=%b actual=%b expected=%b",
                     req, row_n, col_n, act, exp);
        end
    endtask

    // Drive at falling edge, confirm hold (R8), then check after the edge
    task automatic apply(input logic [3:0] r, input logic [3:0] c);
        @(negedge clk);
        row_n = r;
        col_n = c;
        #1;
        compare(prev_exp, "R8");
        @(posedge clk);
        #1;
        prev_exp = model(r, c);
        compare(prev_exp, tag(r, c));
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL R8 watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        row_n = 4'b1110;
        col_n = 4'b1101;
        // R1: reset with a valid pattern present
        @(posedge clk); #1;
        compare('0, "R1");
        @(posedge clk); #1;
        compare('0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        prev_exp = model(row_n, col_n);
        compare(prev_exp, "R2");

        // R2: every lone key
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                apply(~(4'b1 << r), ~(4'b1 << c));

        // R3: every same-row pair
        for (int r = 0; r < 4; r++)
            for (int a = 0; a < 4; a++)
                for (int b = a + 1; b < 4; b++)
                    apply(~(4'b1 << r), ~((4'b1 << a) | (4'b1 << b)));

        // Directed rejects
        apply(4'b1100, 4'b1110);  // R4 two rows
        apply(4'b0000, 4'b0000);  // R4 all rows
        apply(4'b1111, 4'b1110);  // R5 no row
        apply(4'b1111, 4'b1111);  // R5 idle
        apply(4'b1011, 4'b1111);  // R6 bare row
        apply(4'b0111, 4'b1000);  // R7 three cols
        apply(4'b1110, 4'b0000);  // R7 four cols
        apply(4'b0111, 4'b0110);  // R3 top-row pair in last row

        // R1: reset in mid-run clears a held pair
        apply(4'b1101, 4'b0101);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        compare('0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        prev_exp = model(row_n, col_n);
        compare(prev_exp, "R3");

        // Biased random run
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] r;
            logic [3:0] c;
            if ($urandom_range(9) < 7) r = ~(4'b1 << $urandom_range(3));
            else                       r = 4'($urandom);
            case ($urandom_range(3))
                0: c = ~(4'b1 << $urandom_range(3));
                1: c = ~((4'b1 << $urandom_range(3)) | (4'b1 << $urandom_range(3)));
                default: c = 4'($urandom);
            endcase
            apply(r, c);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule